// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time Counter

This block keeps time of day for packet timestamping. It runs from a fixed 125 MHz clock. On every cycle it adds a programmable fixed-point increment to a 28-bit fractional-nanosecond accumulator. Carries out of that accumulator advance a 44-bit nanosecond count. The default increment gives exactly 8 ns per cycle. Software trims the frequency by writing a slightly larger or smaller increment. Writing zero freezes the count.

Software reaches the counter through four 32-bit word registers, selected by a 2-bit word index:

| Index | Byte offset | Contents |
|---|---|---|
| 0 | 0x00 | Nanosecond bits [3:0] |
| 1 | 0x04 | Nanosecond bits [35:4] |
| 2 | 0x08 | Nanosecond bits [43:36] |
| 3 | 0x0C | Increment |

Reading the top field also takes a snapshot of the middle field, so a top-then-middle read pair forms one coherent 40-bit sample. The raw count is also presented directly for use by timestamp capture logic. Extending the count past its wrap is left to software.

Top module: `tod_nco_counter`

## Requirements
- R1: After reset the count and the fraction are zero, and the increment register reads 0x80000000.
- R2: With increment 0x80000000 and no time write, the count rises by exactly 8 every cycle.
- R3: The increment is unsigned fixed point, with bits [31:28] whole nanoseconds and bits [27:0] the fraction. The fraction accumulates, and each carry adds to the count. With 0x18000000 and a cleared fraction, the count gains 3 over two cycles.
- R4: An increment of zero holds the count and the fraction. A newly written increment first applies on the edge after the one that writes it, so counting resumes from the held value.
- R5: Writing index 0 loads count bits [3:0] from wdata[3:0]. Reading index 0 returns those bits in [3:0], with zeros above.
- R6: Writing index 1 loads count bits [35:4] from wdata[31:0].
- R7: Writing index 2 loads count bits [43:36] from wdata[15:8]; the other wdata bits are ignored. Reading index 2 returns those bits in [7:0], with zeros above.
- R8: A time-field write clears the fraction. On that edge the fields not written keep their pre-edge value and the increment is not applied.
- R9: The count is modulo 2^44: from 0xFFFFFFFFFF8 at 8 ns per cycle it becomes 0.
- R10: A read of index 2 captures count bits [35:4] into a snapshot. The next read of index 1 returns the snapshot and consumes it. A read of index 1 with no pending snapshot returns the live bits.
- R11: rdata_o is loaded on the edge where rd_en_i is high, from the state before that edge. It holds when no read is made.
- R12: time_ns_o always shows the current 44-bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 125 MHz counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Word index (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| time_ns_o | output | 44 | Current nanosecond count |

## Verification
Two things can land on the same edge: a time-field write and the increment accumulation. The bench writes single fields while the counter runs at both whole and fractional increments. It expects the written field to take the new value, the other fields to keep their pre-edge value, and the fraction to restart from zero; the count after the next two cycles confirms this. Increment writes made while the counter runs or is halted are judged by when the new rate first appears. A reference model tracks every cycle and is compared on every clock.

// File: rtl/tod_pkg.sv
package tod_pkg;
  parameter int unsigned NS_W     = 44;
  parameter int unsigned FRAC_W   = 28;
  parameter int unsigned DW       = 32;
  parameter int unsigned LOW_W    = 4;
  parameter int unsigned MID_W    = 32;
  parameter int unsigned TOP_LANE = 8;   // write lane lsb of top field
  localparam int unsigned TOP_W   = NS_W - LOW_W - MID_W;
  localparam int unsigned ACC_W   = NS_W + FRAC_W;
  parameter logic [31:0] INC_DEFAULT = 32'h8000_0000;

  typedef enum logic [1:0] {
    SEL_LOW = 2'd0,
    SEL_MID = 2'd1,
    SEL_TOP = 2'd2,
    SEL_INC = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic top;
    logic mid;
    logic low;
  } tload_t;
endpackage

// File: rtl/tod_nco_accum.sv
module tod_nco_accum
  import tod_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DW-1:0]     inc_i,
  input  tload_t            ld_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [NS_W-1:0]   ns_o
);
  logic [ACC_W-1:0] acc_q, acc_sum;
  logic [NS_W-1:0]  ns_cur, ns_ld;
  logic             ld_any;

  assign ns_cur  = acc_q[ACC_W-1:FRAC_W];
  assign ld_any  = |ld_i;
  assign acc_sum = acc_q + {{(ACC_W-DW){1'b0}}, inc_i};

  always_comb begin
    ns_ld = ns_cur;
    if (ld_i.low) ns_ld[LOW_W-1:0]           = wdata_i[LOW_W-1:0];
    if (ld_i.mid) ns_ld[LOW_W+MID_W-1:LOW_W] = wdata_i[MID_W-1:0];
    if (ld_i.top) ns_ld[NS_W-1:LOW_W+MID_W]  = wdata_i[TOP_LANE+TOP_W-1:TOP_LANE];
  end

  // field write wins over accumulation and restarts the fraction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (ld_any) acc_q <= {ns_ld, {FRAC_W{1'b0}}};
    else             acc_q <= acc_sum;
  end

  assign ns_o = ns_cur;

  p_halt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i == '0 && !ld_any) |=> $stable(acc_q));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i == INC_DEFAULT && acc_q[FRAC_W-1:0] == '0 && !ld_any)
      |=> ns_o == $past(ns_o) + NS_W'(8));
  p_frac_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_any |=> acc_q[FRAC_W-1:0] == '0);
  p_low_ld_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i.low |=> ns_o[LOW_W-1:0] == $past(wdata_i[LOW_W-1:0]));
  p_mid_ld_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i.mid |=> ns_o[LOW_W+MID_W-1:LOW_W] == $past(wdata_i[MID_W-1:0]));
  p_top_ld_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i.top |=> ns_o[NS_W-1:LOW_W+MID_W] == $past(wdata_i[TOP_LANE+TOP_W-1:TOP_LANE]));
endmodule

// File: rtl/tod_regif.sv
module tod_regif
  import tod_pkg::*;
#(
  parameter logic [DW-1:0] INC_RST = INC_DEFAULT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [1:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NS_W-1:0] ns_i,
  output logic [DW-1:0]   inc_o,
  output tload_t          ld_o,
  output logic [DW-1:0]   rdata_o
);
  reg_sel_e          sel;
  logic [DW-1:0]     inc_q, rdata_q, rdata_d;
  logic [MID_W-1:0]  shadow_q, mid_live;
  logic              shv_q;

  assign sel      = reg_sel_e'(addr_i);
  assign mid_live = ns_i[LOW_W+MID_W-1:LOW_W];

  always_comb begin
    ld_o     = '0;
    ld_o.low = wr_en_i && sel == SEL_LOW;
    ld_o.mid = wr_en_i && sel == SEL_MID;
    ld_o.top = wr_en_i && sel == SEL_TOP;
  end

  always_comb begin
    unique case (sel)
      SEL_LOW: rdata_d = {{(DW-LOW_W){1'b0}}, ns_i[LOW_W-1:0]};
      SEL_MID: rdata_d = shv_q ? shadow_q : mid_live;
      SEL_TOP: rdata_d = {{(DW-TOP_W){1'b0}}, ns_i[NS_W-1:LOW_W+MID_W]};
      default: rdata_d = inc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_q    <= INC_RST;
      rdata_q  <= '0;
      shadow_q <= '0;
      shv_q    <= 1'b0;
    end else begin
      if (wr_en_i && sel == SEL_INC) inc_q <= wdata_i;
      if (rd_en_i) begin
        rdata_q <= rdata_d;
        if (sel == SEL_TOP) begin
          shadow_q <= mid_live;
          shv_q    <= 1'b1;
        end else if (sel == SEL_MID) begin
          shv_q    <= 1'b0;
        end
      end
    end
  end

  assign inc_o   = inc_q;
  assign rdata_o = rdata_q;

  p_inc_wr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == SEL_INC) |=> inc_o == $past(wdata_i));
  p_snap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel == SEL_TOP) |=> (shv_q && shadow_q == $past(mid_live)));
  p_snap_use_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel == SEL_MID) |=> !shv_q);
  p_rd_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/tod_nco_counter.sv
module tod_nco_counter
  import tod_pkg::*;
#(
  parameter logic [31:0] INC_RST = INC_DEFAULT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NS_W-1:0]   time_ns_o
);
  logic [DW-1:0]   inc;
  tload_t          ld;
  logic [NS_W-1:0] ns;

  tod_regif #(.INC_RST(INC_RST)) u_regif (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .ns_i    (ns),
    .inc_o   (inc),
    .ld_o    (ld),
    .rdata_o (rdata_o)
  );

  tod_nco_accum u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (inc),
    .ld_i    (ld),
    .wdata_i (wdata_i),
    .ns_o    (ns)
  );

  assign time_ns_o = ns;

  p_time_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc == INC_DEFAULT && ns == {NS_W{1'b1}} - NS_W'(7) && ld == '0)
      |=> time_ns_o == '0);
endmodule

// File: tb/tod_nco_counter_test.sv
`timescale 1ns/1ps
module tod_nco_counter_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [43:0] time_ns_o;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  tod_nco_counter uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .time_ns_o(time_ns_o)
  );

  // behavioural reference
  logic [43:0] m_ns;
  logic [27:0] m_frac;
  logic [31:0] m_inc, m_rdata, m_sh;
  bit          m_shv;
  logic [32:0] m_sum;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_ns = '0; m_frac = '0; m_inc = 32'h8000_0000; m_rdata = '0; m_sh = '0; m_shv = 0;
    end else begin
      if (rd_en_i) begin
        case (addr_i)
          2'd0: m_rdata = {28'd0, m_ns[3:0]};
          2'd1: begin m_rdata = m_shv ? m_sh : m_ns[35:4]; m_shv = 0; end
          2'd2: begin m_rdata = {24'd0, m_ns[43:36]}; m_sh = m_ns[35:4]; m_shv = 1; end
          default: m_rdata = m_inc;
        endcase
      end
      if (wr_en_i && addr_i != 2'd3) begin
        if (addr_i == 2'd0) m_ns[3:0]   = wdata_i[3:0];
        if (addr_i == 2'd1) m_ns[35:4]  = wdata_i;
        if (addr_i == 2'd2) m_ns[43:36] = wdata_i[15:8];
        m_frac = '0;
      end else begin
        m_sum  = {5'd0, m_frac} + {1'b0, m_inc};
        m_frac = m_sum[27:0];
        m_ns   = m_ns + 44'(m_sum[32:28]);
      end
      if (wr_en_i && addr_i == 2'd3) m_inc = wdata_i;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) if (rst_ni && !done) begin
    chk("R12 time vs model", 64'(time_ns_o), 64'(m_ns));
    chk("R11 rdata vs model", 64'(rdata_o), 64'(m_rdata));
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [43:0] t, pre;
    logic [31:0] r;
    idle(3);
    rst_ni = 1'b1;
    // R1
    chk("R1 reset time", 64'(time_ns_o), 64'd0);
    rd(2'd3);
    chk("R1 reset increment", 64'(rdata_o), 64'h8000_0000);
    // R2
    t = time_ns_o; idle(1);
    chk("R2 default step", 64'(time_ns_o), 64'(t + 44'd8));
    // R4 halt
    wr(2'd3, 32'd0);
    t = time_ns_o; idle(5);
    chk("R4 halted", 64'(time_ns_o), 64'(t));
    // R7/R6/R5 field loads while halted
    wr(2'd2, 32'hFFFF_A5FF);
    chk("R7 top lane load", 64'(time_ns_o[43:36]), 64'hA5);
    wr(2'd1, 32'h1234_5678);
    chk("R6 mid load", 64'(time_ns_o[35:4]), 64'h1234_5678);
    wr(2'd0, 32'hFFFF_FFF9);
    chk("R5 low load", 64'(time_ns_o), 64'hA5_1234_5678_9);
    rd(2'd0);
    chk("R5 low read", 64'(rdata_o), 64'h9);
    rd(2'd2);
    chk("R7 top read", 64'(rdata_o), 64'hA5);
    rd(2'd1);
    chk("R10 mid after top", 64'(rdata_o), 64'h1234_5678);
    // R9 wrap
    wr(2'd2, 32'h0000_FF00);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, 32'h8);
    chk("R9 preload", 64'(time_ns_o), 64'hFFF_FFFF_FFF8);
    wr(2'd3, 32'h8000_0000);
    chk("R4 new increment not yet applied", 64'(time_ns_o), 64'hFFF_FFFF_FFF8);
    idle(1);
    chk("R9 wrap to zero", 64'(time_ns_o), 64'd0);
    idle(1);
    chk("R9 after wrap", 64'(time_ns_o), 64'd8);
    // R3 fractional increment 1.5 ns
    wr(2'd3, 32'h1800_0000);
    wr(2'd0, 32'h0);
    t = time_ns_o; idle(1);
    chk("R3 first half step", 64'(time_ns_o), 64'(t + 44'd1));
    idle(1);
    chk("R3 two cycles", 64'(time_ns_o), 64'(t + 44'd3));
    idle(2);
    chk("R3 four cycles", 64'(time_ns_o), 64'(t + 44'd6));
    // R8 write against running counter
    idle(1);
    pre = time_ns_o;
    wr(2'd1, 32'h0000_0010);
    chk("R8 mid write overrides step", 64'(time_ns_o), 64'({pre[43:36], 32'h10, pre[3:0]}));
    t = time_ns_o; idle(2);
    chk("R8 fraction cleared", 64'(time_ns_o), 64'(t + 44'd3));
    wr(2'd3, 32'h8000_0000);
    idle(3);
    pre = time_ns_o;
    wr(2'd0, 32'h3);
    chk("R8 low write keeps upper", 64'(time_ns_o), 64'({pre[43:4], 4'h3}));
    // R10 coherent read
    idle(2);
    pre = time_ns_o;
    rd(2'd2);
    chk("R10 top sample", 64'(rdata_o), 64'(pre[43:36]));
    idle(3);
    rd(2'd1);
    chk("R10 snapshot returned", 64'(rdata_o), 64'(pre[35:4]));
    pre = time_ns_o;
    rd(2'd1);
    chk("R10 live after consume", 64'(rdata_o), 64'(pre[35:4]));
    // R11 hold
    r = rdata_o;
    wr(2'd0, 32'h5);
    idle(3);
    chk("R11 rdata hold", 64'(rdata_o), 64'(r));
    rd(2'd3);
    chk("R11 increment read", 64'(rdata_o), 64'h8000_0000);
    idle(2);
    finish_run();
  end
endmodule